// File: doc/BRIEF.md
# Burst-Aware Preload Update Controller

This block decides when register values written during a burst transfer move from their preload (shadow) copies into the active registers. A burst sequencer gives it one write strobe per register, a pulse when the burst completes, and regular timer update requests as single-cycle pulses. The block also takes a preload enable and a two-bit burst update mode. Its only output is one load enable per active register. The counter, the timer and the data path are outside the block.

With preload off, every write goes straight to its active register, so registers change one at a time as the transfer proceeds. With preload on, each register keeps a shadow-valid bit that marks a write since the last transfer. A transfer event loads exactly those registers and clears their bits. The mode picks the transfer event:
- mode 0 uses regular update requests only, whatever the state of the burst;
- mode 1 also transfers when the burst completes;
- mode 2 transfers on the first regular request after the burst completes and drops requests that arrive during a burst;
- mode 3 is reserved and behaves like mode 0.

All load enables come from registers and rise in the cycle after the triggering inputs are sampled.

Top module: `burst_preload_ctrl`

## Requirements
- R1: With preload_en low, load_en in cycle k+1 equals wr_strobe in cycle k, bit i of each vector being register i. Nothing is retained, so a later transfer with preload_en high loads none of those registers.
- R2: With preload_en high, a write sets the register's shadow-valid bit, and a transfer event in cycle k drives load_en in cycle k+1 to the set of shadow-valid registers together with the strobes of cycle k. The transfer then clears those bits. Registers not written since the last transfer are not loaded, and load_en is zero in every cycle after a cycle without a transfer event.
- R3: In mode 0 (burst_mode = 2'b00), every upd_req is a transfer event regardless of burst progress. A request in mid-burst loads only the registers written so far, and a second request loads the rest.
- R4: In mode 1 (burst_mode = 2'b01), burst_done is a transfer event, so all registers of the burst load together.
- R5: In mode 1, upd_req is also a transfer event.
- R6: In mode 2 (burst_mode = 2'b10), a burst is in progress from the cycle after its first write through the cycle in which burst_done is high. An upd_req in that window is discarded and loads nothing.
- R7: In mode 2, burst_done alone loads nothing. The first upd_req after burst_done, outside a burst, is the transfer event, and further requests load nothing until another burst_done.
- R8: Mode 3 (burst_mode = 2'b11) behaves exactly like mode 0.
- R9: After reset, load_en is zero, no shadow bit is valid, no burst is in progress and no mode-2 transfer is pending.
- R10: Any cycle with preload_en low discards all shadow-valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| preload_en | input | 1 | 1 = values are held in shadow storage until a transfer event |
| burst_mode | input | 2 | Transfer event select: 0 on update, 1 on completion, 2 after completion, 3 reserved (as 0) |
| wr_strobe | input | NUM_REGS | Per-register write strobe from the burst sequencer |
| burst_done | input | 1 | Single-cycle pulse marking the end of a burst |
| upd_req | input | 1 | Single-cycle regular timer update request |
| load_en | output | NUM_REGS | Per-register load enable into active storage |

## Verification
The bench builds the block with NUM_REGS = 4. With that size, the pseudo-random stimulus covers every one of the 16 strobe patterns many times in each of the four modes, with preload both on and off. Directed sequences cover the following cases:
- requests arriving in mid-burst;
- a request coinciding with burst completion;
- repeated requests after a mode-2 transfer;
- preload being switched off while shadow bits are still valid.

Each result is compared with a model that restates the requirements cycle by cycle.

// File: rtl/bupc_pkg.sv
package bupc_pkg;

  typedef enum logic [1:0] {
    BMODE_ON_UPDATE  = 2'd0,
    BMODE_ON_DONE    = 2'd1,
    BMODE_AFTER_DONE = 2'd2,
    BMODE_RESERVED   = 2'd3
  } bmode_e;

  // Transfer event for the selected mode.
  function automatic logic fire_fn(bmode_e mode, logic upd, logic done,
                                   logic pend, logic busy);
    case (mode)
      BMODE_ON_DONE:    return upd | done;
      BMODE_AFTER_DONE: return upd & pend & ~busy;
      default:          return upd;
    endcase
  endfunction

  // A burst runs from its first write until completion.
  function automatic logic busy_next_fn(logic busy, logic any_wr, logic done);
    return done ? 1'b0 : (busy | any_wr);
  endfunction

  // The pending flag lives only in mode 2.
  function automatic logic pend_next_fn(bmode_e mode, logic pend, logic done,
                                        logic fire);
    return (mode == BMODE_AFTER_DONE) & (done | (pend & ~fire));
  endfunction

  function automatic logic shadow_next_fn(logic pre, logic fire, logic sh,
                                          logic wr);
    return pre & ~fire & (sh | wr);
  endfunction

  function automatic logic load_next_fn(logic pre, logic fire, logic sh,
                                        logic wr);
    return pre ? (fire & (sh | wr)) : wr;
  endfunction

endpackage

// File: rtl/bupc_seq_track.sv
module bupc_seq_track
  import bupc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  bmode_e mode_i,
  input  logic   any_wr_i,
  input  logic   burst_done_i,
  input  logic   upd_req_i,
  output logic   busy_o,
  output logic   pend_o,
  output logic   fire_o
);

  logic busy_q;
  logic pend_q;

  assign fire_o = fire_fn(mode_i, upd_req_i, burst_done_i, pend_q, busy_q);
  assign busy_o = busy_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy_next_fn(busy_q, any_wr_i, burst_done_i);
      pend_q <= pend_next_fn(mode_i, pend_q, burst_done_i, fire_o);
    end
  end

endmodule

// File: rtl/bupc_shadow_bank.sv
module bupc_shadow_bank
  import bupc_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preload_en_i,
  input  logic                fire_i,
  input  logic [NUM_REGS-1:0] wr_strobe_i,
  output logic [NUM_REGS-1:0] shadow_vld_o,
  output logic [NUM_REGS-1:0] load_en_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic sh_q;
    logic ld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= 1'b0;
        ld_q <= 1'b0;
      end else begin
        sh_q <= shadow_next_fn(preload_en_i, fire_i, sh_q, wr_strobe_i[g]);
        ld_q <= load_next_fn(preload_en_i, fire_i, sh_q, wr_strobe_i[g]);
      end
    end

    assign shadow_vld_o[g] = sh_q;
    assign load_en_o[g]    = ld_q;
  end

endmodule

// File: rtl/burst_preload_ctrl.sv
module burst_preload_ctrl
  import bupc_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preload_en,
  input  logic [1:0]          burst_mode,
  input  logic [NUM_REGS-1:0] wr_strobe,
  input  logic                burst_done,
  input  logic                upd_req,
  output logic [NUM_REGS-1:0] load_en
);

  bmode_e              mode;
  logic                any_wr;
  logic                trk_busy;
  logic                trk_pend;
  logic                xfer_fire;
  logic [NUM_REGS-1:0] shadow_vld;

  assign mode   = bmode_e'(burst_mode);
  assign any_wr = |wr_strobe;

  bupc_seq_track trk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .any_wr_i     (any_wr),
    .burst_done_i (burst_done),
    .upd_req_i    (upd_req),
    .busy_o       (trk_busy),
    .pend_o       (trk_pend),
    .fire_o       (xfer_fire)
  );

  bupc_shadow_bank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .preload_en_i (preload_en),
    .fire_i       (xfer_fire),
    .wr_strobe_i  (wr_strobe),
    .shadow_vld_o (shadow_vld),
    .load_en_o    (load_en)
  );

endmodule

// File: rtl/bupc_checker.sv
module bupc_checker #(
  parameter int NUM_REGS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                preload_en,
  input logic [1:0]          burst_mode,
  input logic [NUM_REGS-1:0] wr_strobe,
  input logic                burst_done,
  input logic                upd_req,
  input logic [NUM_REGS-1:0] load_en,
  input logic                trk_busy,
  input logic                trk_pend,
  input logic                xfer_fire,
  input logic [NUM_REGS-1:0] shadow_vld
);

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_en |=> (load_en == $past(wr_strobe))); // R1

  AST_QUIET_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !xfer_fire) |=> (load_en == '0)); // R2

  AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && (burst_mode == 2'd0) && upd_req)
      |=> (load_en == $past(shadow_vld | wr_strobe))); // R3

  AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && (burst_mode == 2'd1) && burst_done)
      |=> (load_en == $past(shadow_vld | wr_strobe))); // R4

  AST_RSVD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && (burst_mode == 2'd3) && upd_req)
      |=> (load_en == $past(shadow_vld | wr_strobe))); // R8

  AST_BUSY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_mode == 2'd2) && trk_busy) |-> !xfer_fire); // R6

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk_busy && (|wr_strobe) && !burst_done) |=> trk_busy); // R6

  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_mode == 2'd2) && xfer_fire && !burst_done) |=> !trk_pend); // R7

  AST_PRELOAD_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_en |=> (shadow_vld == '0)); // R10

endmodule

bind burst_preload_ctrl bupc_checker #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .preload_en (preload_en),
  .burst_mode (burst_mode),
  .wr_strobe  (wr_strobe),
  .burst_done (burst_done),
  .upd_req    (upd_req),
  .load_en    (load_en),
  .trk_busy   (trk_busy),
  .trk_pend   (trk_pend),
  .xfer_fire  (xfer_fire),
  .shadow_vld (shadow_vld)
);

// File: tb/burst_preload_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_preload_ctrl_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         preload_en = 1'b0;
  logic [1:0]   burst_mode = 2'd0;
  logic [N-1:0] wr_strobe = '0;
  logic         burst_done = 1'b0;
  logic         upd_req = 1'b0;
  logic [N-1:0] load_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // expectation state
  logic [N-1:0] m_sh;
  logic         m_busy;
  logic         m_pend;

  always #2 clk = ~clk;

  burst_preload_ctrl #(.NUM_REGS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .preload_en(preload_en), .burst_mode(burst_mode),
    .wr_strobe(wr_strobe), .burst_done(burst_done), .upd_req(upd_req),
    .load_en(load_en)
  );

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: load_en act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_strobe = '0; burst_done = 1'b0; upd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9", load_en, '0);
    rst_n = 1'b1;
    m_sh = '0; m_busy = 1'b0; m_pend = 1'b0;
  endtask

  // One cycle: drive, compute expectation from the requirements, compare.
  task automatic cyc(input string tag, input logic pre, input logic [1:0] md,
                     input logic [N-1:0] st, input logic dn, input logic up);
    logic         go;
    logic [N-1:0] exp;
    preload_en = pre; burst_mode = md; wr_strobe = st;
    burst_done = dn;  upd_req = up;
    if (md == 2'd1)      go = up || dn;
    else if (md == 2'd2) go = up && m_pend && !m_busy;
    else                 go = up;
    if (!pre)    exp = st;
    else if (go) exp = m_sh | st;
    else         exp = '0;
    if (!pre || go) m_sh = '0;
    else            m_sh = m_sh | st;
    if (md == 2'd2) m_pend = dn || (m_pend && !go);
    else            m_pend = 1'b0;
    if (dn)              m_busy = 1'b0;
    else if (st != '0)   m_busy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag, load_en, exp);
    wr_strobe = '0; burst_done = 1'b0; upd_req = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    string       tg;
    do_reset();
    cyc("R9", 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1);
    check("R9", load_en, 4'b0000);

    // R1 direct pass, nothing retained
    do_reset();
    cyc("R1", 1'b0, 2'd0, 4'b0101, 1'b0, 1'b0);
    check("R1", load_en, 4'b0101);
    cyc("R1", 1'b0, 2'd0, 4'b0010, 1'b0, 1'b0);
    check("R1", load_en, 4'b0010);
    cyc("R1", 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1);
    check("R1", load_en, 4'b0000);

    // R3 mode 0, split burst needs two updates
    do_reset();
    cyc("R3", 1'b1, 2'd0, 4'b0001, 1'b0, 1'b0);
    check("R2", load_en, 4'b0000);
    cyc("R3", 1'b1, 2'd0, 4'b0010, 1'b0, 1'b0);
    cyc("R3", 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1);
    check("R3", load_en, 4'b0011);
    cyc("R3", 1'b1, 2'd0, 4'b0100, 1'b0, 1'b0);
    cyc("R3", 1'b1, 2'd0, 4'b1000, 1'b1, 1'b0);
    check("R3", load_en, 4'b0000);
    cyc("R3", 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1);
    check("R3", load_en, 4'b1100);
    cyc("R2", 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1);
    check("R2", load_en, 4'b0000);

    // R4 / R5 mode 1
    do_reset();
    cyc("R4", 1'b1, 2'd1, 4'b0011, 1'b0, 1'b0);
    cyc("R4", 1'b1, 2'd1, 4'b0100, 1'b0, 1'b0);
    check("R4", load_en, 4'b0000);
    cyc("R4", 1'b1, 2'd1, 4'b0000, 1'b1, 1'b0);
    check("R4", load_en, 4'b0111);
    cyc("R5", 1'b1, 2'd1, 4'b1000, 1'b0, 1'b0);
    cyc("R5", 1'b1, 2'd1, 4'b0000, 1'b0, 1'b1);
    check("R5", load_en, 4'b1000);

    // R6 / R7 mode 2
    do_reset();
    cyc("R6", 1'b1, 2'd2, 4'b0001, 1'b0, 1'b0);
    cyc("R6", 1'b1, 2'd2, 4'b0000, 1'b0, 1'b1);
    check("R6", load_en, 4'b0000);
    cyc("R6", 1'b1, 2'd2, 4'b0010, 1'b1, 1'b1);
    check("R6", load_en, 4'b0000);
    cyc("R7", 1'b1, 2'd2, 4'b0000, 1'b0, 1'b1);
    check("R7", load_en, 4'b0011);
    cyc("R7", 1'b1, 2'd2, 4'b0000, 1'b0, 1'b1);
    check("R7", load_en, 4'b0000);
    cyc("R7", 1'b1, 2'd2, 4'b0100, 1'b0, 1'b0);
    cyc("R7", 1'b1, 2'd2, 4'b0000, 1'b1, 1'b0);
    check("R7", load_en, 4'b0000);
    cyc("R7", 1'b1, 2'd2, 4'b0000, 1'b0, 1'b1);
    check("R7", load_en, 4'b0100);

    // R8 reserved mode
    do_reset();
    cyc("R8", 1'b1, 2'd3, 4'b0110, 1'b0, 1'b0);
    cyc("R8", 1'b1, 2'd3, 4'b0000, 1'b0, 1'b1);
    check("R8", load_en, 4'b0110);
    cyc("R8", 1'b1, 2'd3, 4'b1001, 1'b0, 1'b0);
    cyc("R8", 1'b1, 2'd3, 4'b0000, 1'b1, 1'b0);
    check("R8", load_en, 4'b0000);

    // R10 preload off drops shadow bits
    do_reset();
    cyc("R10", 1'b1, 2'd0, 4'b1111, 1'b0, 1'b0);
    cyc("R10", 1'b0, 2'd0, 4'b0000, 1'b0, 1'b0);
    check("R10", load_en, 4'b0000);
    cyc("R10", 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1);
    check("R10", load_en, 4'b0000);

    // pseudo-random sweep over every mode and preload setting
    lf = 16'hACE1;
    for (int pre = 0; pre < 2; pre++) begin
      for (int md = 0; md < 4; md++) begin
        do_reset();
        if (pre == 0)     tg = "R1";
        else if (md == 0) tg = "R3";
        else if (md == 1) tg = "R4";
        else if (md == 2) tg = "R6";
        else              tg = "R8";
        for (int k = 0; k < 400; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          cyc(tg, pre[0], md[1:0],
              (lf[6:4] < 3'd3) ? lf[3:0] : 4'b0000,
              lf[9:7] == 3'd0, lf[12:10] < 3'd2);
        end
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule